// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 12-bit successive-approximation converter. The comparator, the trial DAC and the input switches sit outside it. The sequencer waits for a start request and captures a 5-bit setup word. It then lets the sampling switch track the input for a fixed acquisition time, or until a host hold request arrives. After that it closes the hold and walks a trial code from the most significant bit down to the least. One comparator answer is used per clock. When the last bit is settled, the finished code goes into a result register.

A single active-low busy output shows when a conversion is in flight and doubles as the completion signal. The hold control output is high only while bits are being decided. Tracking therefore starts again in the same cycle that the result appears.

The sequencer has four named states:
- `ST_IDLE`: tracking, busy high.
- `ST_ACQ`: timed acquisition.
- `ST_WAIT_HOLD`: acquisition timed by the host.
- `ST_CONV`: bit decisions.

It has these transitions:
- **accept**: `ST_IDLE` to `ST_ACQ` or `ST_WAIT_HOLD` on a start request, depending on the external-hold option.
- **acq_done**: `ST_ACQ` to `ST_CONV` after the third acquisition cycle.
- **host_hold**: `ST_WAIT_HOLD` to `ST_CONV` on a hold request.
- **last_bit**: `ST_CONV` to `ST_IDLE` after the twelfth decision.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A synchronous reset sets the result to 0, drives busy high and puts the hold control low (track). A reset in the middle of a conversion aborts it.
- R2: A start request sampled while busy is high copies `cfg_i` into `cfg_o` on that same edge. The fields are [2:0] channel, [3] differential and [4] bipolar. `cfg_o` does not change while busy is low.
- R3: With the external-hold option low at start, busy is low from the cycle after the start edge. Hold stays low for exactly 3 busy cycles and then goes high.
- R4: With the external-hold option high at start, hold stays low until a hold request is sampled. Hold goes high in the cycle after that edge, so the number of hold-low busy cycles equals the cycle count of the host wait.
- R5: In the first hold-high cycle the trial code is 0x800. In hold cycle i (0..11), every bit above position 11-i holds its already decided value, bit 11-i is 1, and all lower bits are 0.
- R6: A comparator input of 1 means the trial value exceeds the input, and it clears the bit under test. Otherwise that bit is kept. For a comparator that reports trial > v, the final result equals v.
- R7: The result register changes only on the edge of the last decision. It keeps its old value during every busy cycle.
- R8: Hold is high for exactly 12 cycles per conversion. In the timed mode busy is low for exactly 15 cycles.
- R9: In the first cycle with busy high again, hold is low and the new result is visible.
- R10: Start requests and hold requests that arrive while busy is low are ignored. This includes a start in the final decision cycle. Hold requests are also ignored in the timed mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request, sampled while idle |
| ext_hold_i | input | 1 | 1 at start: host decides the hold moment |
| hold_req_i | input | 1 | Host hold request, used in the external-hold wait only |
| cfg_i | input | 5 | Setup word: [2:0] channel, [3] differential, [4] bipolar |
| cmp_i | input | 1 | Comparator: 1 when the trial value exceeds the input |
| hold_o | output | 1 | 1 = hold, 0 = track |
| busy_n_o | output | 1 | Low while a conversion runs |
| dac_code_o | output | 12 | Trial code for the external DAC |
| result_o | output | 12 | Last finished conversion |
| cfg_o | output | 5 | Setup word captured at the last accepted start |

## Verification
Two events can share a cycle: the last bit decision, which writes the result and returns to idle, and a fresh start request. The bench raises `start_i` with a different setup word during the final hold-high cycle of every timed conversion. It also injects a stray start and hold request early in acquisition. The run is judged correct if the finished result still equals the modelled input, busy stays high in the following cycle and `cfg_o` keeps the original setup word. The bench then sweeps all 4096 input codes, and runs the external-hold mode with varied wait lengths to confirm the decoupled hold timing.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int CHAN_W = 3;

    // Setup word captured at conversion start: [4] bipolar, [3] differential, [2:0] channel
    typedef struct packed {
        logic              bipolar;
        logic              diff;
        logic [CHAN_W-1:0] chan;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQ,
        ST_WAIT_HOLD,
        ST_CONV
    } seq_state_t;

endpackage

// File: rtl/sar_cfg_hold.sv
module sar_cfg_hold
    import sar_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  cfg_t cfg_i,
    output cfg_t cfg_o
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load_i) begin
            cfg_q <= cfg_i;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int ACQ_CYCLES = 3,
    localparam int IDX_W     = $clog2(DATA_W + 1),
    localparam int CNT_W     = $clog2(ACQ_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             ext_hold_i,
    input  logic             hold_req_i,
    output logic             load_cfg_o,
    output logic             seed_o,
    output logic             step_o,
    output logic             done_o,
    output logic [IDX_W-1:0] bit_idx_o,
    output logic             busy_n_o,
    output logic             hold_o
);

    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] ACQ_LAST = CNT_W'(ACQ_CYCLES - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] acq_cnt_q, acq_cnt_d;
    logic [IDX_W-1:0] bit_q, bit_d;

    // State register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            acq_cnt_q <= '0;
            bit_q     <= '0;
        end else begin
            state_q   <= state_d;
            acq_cnt_q <= acq_cnt_d;
            bit_q     <= bit_d;
        end
    end

    // Next-state and strobe decode
    always_comb begin
        state_d    = state_q;
        acq_cnt_d  = acq_cnt_q;
        bit_d      = bit_q;
        load_cfg_o = 1'b0;
        seed_o     = 1'b0;
        step_o     = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    // accept
                    load_cfg_o = 1'b1;
                    acq_cnt_d  = '0;
                    state_d    = ext_hold_i ? ST_WAIT_HOLD : ST_ACQ;
                end
            end
            ST_ACQ: begin
                if (acq_cnt_q == ACQ_LAST) begin
                    // acq_done
                    seed_o  = 1'b1;
                    bit_d   = TOP_IDX;
                    state_d = ST_CONV;
                end else begin
                    acq_cnt_d = acq_cnt_q + CNT_W'(1);
                end
            end
            ST_WAIT_HOLD: begin
                if (hold_req_i) begin
                    // host_hold
                    seed_o  = 1'b1;
                    bit_d   = TOP_IDX;
                    state_d = ST_CONV;
                end
            end
            ST_CONV: begin
                step_o = 1'b1;
                if (bit_q == '0) begin
                    // last_bit
                    done_o  = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    bit_d = bit_q - IDX_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        busy_n_o  = (state_q == ST_IDLE);
        hold_o    = (state_q == ST_CONV);
        bit_idx_o = bit_q;
    end

    // R3
    acq_to_conv_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACQ && acq_cnt_q == ACQ_LAST) |=> (state_q == ST_CONV && bit_q == TOP_IDX));

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_HOLD && !hold_req_i) |=> (state_q == ST_WAIT_HOLD));

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && bit_q != '0) |=> (state_q == ST_CONV));

    // R8
    hold_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        hold_o |-> !busy_n_o);

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int DATA_W    = 12,
    localparam int IDX_W    = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_i,
    input  logic              step_i,
    input  logic              done_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    input  logic              cmp_i,
    output logic [DATA_W-1:0] trial_o,
    output logic [DATA_W-1:0] result_o
);

    localparam logic [DATA_W-1:0] MSB_ONLY = DATA_W'(1) << (DATA_W - 1);

    logic [DATA_W-1:0] trial_q, trial_nxt, result_q;

    // Per-bit decision: resolve the bit under test, arm the one below it
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign trial_nxt[b] = (IDX_W'(b) == bit_idx_i)     ? ~cmp_i :
                              (IDX_W'(b + 1) == bit_idx_i) ? 1'b1   :
                                                             trial_q[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trial_q  <= '0;
            result_q <= '0;
        end else begin
            if (seed_i) begin
                trial_q <= MSB_ONLY;
            end else if (step_i) begin
                trial_q <= trial_nxt;
            end
            if (done_i) begin
                result_q <= trial_nxt;
            end
        end
    end

    assign trial_o  = trial_q;
    assign result_o = result_q;

    // R5
    seed_msb_chk: assert property (@(posedge clk) disable iff (rst)
        seed_i |=> (trial_q == MSB_ONLY));

    // R5
    upper_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !seed_i) |=> ((trial_q >> (int'($past(bit_idx_i)) + 1))
                                 == ($past(trial_q) >> (int'($past(bit_idx_i)) + 1))));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_i |=> $stable(result_q));

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int ACQ_CYCLES = 3,
    localparam int IDX_W     = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              ext_hold_i,
    input  logic              hold_req_i,
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic              cmp_i,
    output logic              hold_o,
    output logic              busy_n_o,
    output logic [DATA_W-1:0] dac_code_o,
    output logic [DATA_W-1:0] result_o,
    output logic [CFG_W-1:0]  cfg_o
);

    logic             load_cfg, seed, step, done;
    logic [IDX_W-1:0] bit_idx;
    cfg_t             cfg_held;

    sar_seq_fsm #(
        .DATA_W     (DATA_W),
        .ACQ_CYCLES (ACQ_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .ext_hold_i (ext_hold_i),
        .hold_req_i (hold_req_i),
        .load_cfg_o (load_cfg),
        .seed_o     (seed),
        .step_o     (step),
        .done_o     (done),
        .bit_idx_o  (bit_idx),
        .busy_n_o   (busy_n_o),
        .hold_o     (hold_o)
    );

    sar_trial_reg #(
        .DATA_W (DATA_W)
    ) u_trial (
        .clk       (clk),
        .rst       (rst),
        .seed_i    (seed),
        .step_i    (step),
        .done_i    (done),
        .bit_idx_i (bit_idx),
        .cmp_i     (cmp_i),
        .trial_o   (dac_code_o),
        .result_o  (result_o)
    );

    sar_cfg_hold u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_cfg),
        .cfg_i  (cfg_t'(cfg_i)),
        .cfg_o  (cfg_held)
    );

    assign cfg_o = CFG_W'(cfg_held);

    // R2
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_n_o |=> $stable(cfg_o));

    // R9
    track_on_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_n_o) |-> !hold_o);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (busy_n_o && !hold_o && result_o == '0));

endmodule

// File: tb/tb_sar_seq_ctrl.sv
module tb_sar_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         ext_hold_i = 1'b0;
    logic         hold_req_i = 1'b0;
    logic [4:0]   cfg_i = '0;
    logic         cmp_i;
    logic         hold_o, busy_n_o;
    logic [W-1:0] dac_code_o, result_o;
    logic [4:0]   cfg_o;
    logic [W-1:0] vin_q = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit reported = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Comparator model: 1 when the trial value exceeds the modelled input
    assign cmp_i = (dac_code_o > vin_q);

    sar_seq_ctrl dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .ext_hold_i (ext_hold_i),
        .hold_req_i (hold_req_i),
        .cfg_i      (cfg_i),
        .cmp_i      (cmp_i),
        .hold_o     (hold_o),
        .busy_n_o   (busy_n_o),
        .dac_code_o (dac_code_o),
        .result_o   (result_o),
        .cfg_o      (cfg_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            report();
        end
    end

    // One conversion; all sampling at falling edges
    task automatic run_conv(input int vin, input bit ext, input int dly, input logic [4:0] cfg);
        int n_busy = 0;
        int n_hold = 0;
        int n_acq  = 0;
        int prev_res;
        int expc;
        vin_q = W'(vin);
        @(negedge clk);
        start_i = 1'b1; ext_hold_i = ext; cfg_i = cfg;
        @(negedge clk);
        start_i = 1'b0; cfg_i = ~cfg;
        chk("R3 busy low after start", int'(busy_n_o), 0);
        chk("R2 cfg captured", int'(cfg_o), int'(cfg));
        prev_res = int'(result_o);
        while (busy_n_o == 1'b0 && n_busy < 40) begin
            n_busy++;
            if (hold_o) begin
                expc = (vin & ~((1 << (W - n_hold)) - 1)) | (1 << (W - 1 - n_hold));
                chk("R5 R6 trial code", int'(dac_code_o), expc);
                n_hold++;
            end else begin
                n_acq++;
            end
            chk("R7 result held", int'(result_o), prev_res);
            if (ext && !hold_o && n_acq == dly) hold_req_i = 1'b1;
            if (!ext && n_busy == 2) begin
                // R10 stray start and hold request during acquisition
                start_i = 1'b1; hold_req_i = 1'b1;
            end
            if (n_hold == W) start_i = 1'b1;   // start on the final decision cycle
            @(negedge clk);
            start_i = 1'b0; hold_req_i = 1'b0;
        end
        chk("R9 hold low at end", int'(hold_o), 0);
        chk("R6 result", int'(result_o), vin);
        chk("R8 hold cycles", n_hold, W);
        if (ext) begin
            chk("R4 host wait cycles", n_acq, dly);
        end else begin
            chk("R3 acquisition cycles", n_acq, 3);
            chk("R8 busy cycles", n_busy, 15);
        end
        chk("R10 cfg kept", int'(cfg_o), int'(cfg));
        @(negedge clk);
        chk("R10 no restart", int'(busy_n_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 busy after reset", int'(busy_n_o), 1);
        chk("R1 hold after reset", int'(hold_o), 0);
        chk("R1 result after reset", int'(result_o), 0);

        // R10: hold request while idle in the timed mode does nothing
        @(negedge clk); hold_req_i = 1'b1;
        @(negedge clk); hold_req_i = 1'b0;
        chk("R10 idle hold request", int'(hold_o), 0);

        // Full sweep, timed acquisition
        for (int v = 0; v < (1 << W); v++) begin
            run_conv(v, 1'b0, 0, 5'(v * 7));
        end

        // Host-timed hold with several wait lengths
        for (int k = 0; k < 48; k++) begin
            run_conv((k * 997 + 13) % (1 << W), 1'b1, 1 + (k % 8), 5'(k));
        end

        // R1: reset in mid-conversion aborts it
        vin_q = 12'hABC;
        @(negedge clk); start_i = 1'b1; ext_hold_i = 1'b0;
        @(negedge clk); start_i = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 busy after mid reset", int'(busy_n_o), 1);
        chk("R1 hold after mid reset", int'(hold_o), 0);
        chk("R1 result after mid reset", int'(result_o), 0);

        report();
    end

endmodule